// File: doc/BRIEF.md
# Lockable Watchdog Timer

A memory-mapped watchdog for a simple 32-bit register bus with a setup phase and an access phase. Software programs a reload value and turns the timer on. A down-counter then runs from that value. Each time the count period runs out, the timer raises an interrupt and reloads itself. If the interrupt is still pending when the next period runs out, and the reset output is enabled, the block asserts its reset request. Software keeps the system alive by acknowledging the interrupt before then.

Writes to the configuration can be frozen. Any value other than a 32-bit key, written to the key register, locks them. Writing the key unlocks them again. A test mode lets software drive both output pins from register bits. A few read-only identification bytes complete the map. The reset input is asserted asynchronously and released through a two-flop synchroniser.

Register offsets (byte addresses): reload 0x00, live count 0x04, control 0x08 (bit 0 run/interrupt enable, bit 1 reset enable), acknowledge 0x0C, raw status 0x10, masked status 0x14, key 0x18, test select 0x1C (bit 0), test pins 0x20 (bit 0 interrupt, bit 1 reset), identification bytes 0x30, 0x34, 0x38 and 0x3C. Each identification register holds one byte of `ID_WORD`, least significant byte first.

Top module: `wdog_lockable`

## Requirements
- R1: A write to the reload register (0x00) restarts the count at once: from the cycle after the write, the live count (0x04) reads the written value.
- R2: A reload write of 0 is stored and used as 1, so the live count is never 0.
- R3: The live count register (0x04) returns the current count and ignores writes.
- R4: Control bit 0 = 1 decrements the count once per clock and enables the interrupt pin. With bit 0 = 0, the count holds and the interrupt pin stays low.
- R5: Control bit 1 enables the reset pin. With bit 1 = 0 and test mode off, the reset pin is low.
- R6: Raw status (0x10, bit 0) shows the pending interrupt whatever the enable. Masked status (0x14, bit 0) is the pending interrupt ANDed with control bit 0.
- R7: When the count is 1 on a running clock, the count reloads and the interrupt becomes pending, so a reload of N gives one expiry every N cycles. An expiry that finds the interrupt already pending, with control bit 1 set, sets a reset request. That request stays set until block reset.
- R8: Any write to 0x0C clears the pending interrupt and reloads the count from the reload register. This write takes priority over an expiry in the same cycle.
- R9: Writing 0x1ACCE551 to 0x18 unlocks writes, and any other value locks them. The key register stays writable while locked. Reading 0x18 returns 1 when locked and 0 when unlocked. Writes to other registers while locked have no effect. The block leaves reset unlocked.
- R10: With test select bit 0 set, the interrupt pin follows test-pin bit 0 and the reset pin follows test-pin bit 1.
- R11: The identification registers return the bytes of `ID_WORD`. Unmapped offsets read 0.
- R12: After reset, the reload and count registers hold `RESET_LOAD`. Control, test, status and reset request are 0, and both pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Block select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from addressed register |
| irq_o | output | 1 | Interrupt pin |
| rst_req_o | output | 1 | Reset request pin |

## Verification
A write lands on the clock edge that ends its access phase. A read returns the state as of the last edge, during the access phase, with no wait states. The count, the pending flag and the reset request move on the edge after the stimulus that causes them, and the pins follow those registers without further delay. A behavioural model in the bench advances on the same edge as the design and is compared with the pins at every falling edge. Read data is compared in the middle of the access phase, so each result is sampled exactly one edge after its cause.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_ACK   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MSK   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_KEY   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_TSEL  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_TPIN  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_ID0   = 8'h30;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int               CNT_W      = 32,
  parameter logic [CNT_W-1:0] RESET_LOAD = '1,
  parameter int               ID_BYTES   = 4,
  parameter logic [8*ID_BYTES-1:0] ID_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              pend_i,
  output logic              load_wr_o,
  output logic [CNT_W-1:0]  load_new_o,
  output logic [CNT_W-1:0]  load_q_o,
  output logic              ack_wr_o,
  output logic              run_o,
  output logic              rst_en_o,
  output logic              tsel_o,
  output logic [1:0]        tpin_o
);
  logic acc, open_wr, key_wr;
  logic lock_q, lock_d;
  logic [CNT_W-1:0] load_q, wclamp;
  logic run_q, rst_en_q, tsel_q;
  logic [1:0] tpin_q;
  logic load_en, ctrl_en, tsel_en, tpin_en;
  logic [DATA_W-1:0] id_rd;
  logic [ID_BYTES-1:0][DATA_W-1:0] id_words;

  // next-state
  always_comb begin
    acc     = psel_i & penable_i & pwrite_i;
    key_wr  = acc && (paddr_i == OFS_KEY);
    open_wr = acc && !lock_q;
    lock_d  = key_wr ? (pwdata_i != UNLOCK_KEY) : lock_q;
    wclamp  = (pwdata_i[CNT_W-1:0] == '0) ? CNT_W'(1) : pwdata_i[CNT_W-1:0];
    load_en = open_wr && (paddr_i == OFS_LOAD);
    ctrl_en = open_wr && (paddr_i == OFS_CTRL);
    tsel_en = open_wr && (paddr_i == OFS_TSEL);
    tpin_en = open_wr && (paddr_i == OFS_TPIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      load_q   <= RESET_LOAD;
      run_q    <= 1'b0;
      rst_en_q <= 1'b0;
      tsel_q   <= 1'b0;
      tpin_q   <= 2'b00;
    end else begin
      lock_q <= lock_d;
      if (load_en) load_q <= wclamp;
      if (ctrl_en) begin
        run_q    <= pwdata_i[0];
        rst_en_q <= pwdata_i[1];
      end
      if (tsel_en) tsel_q <= pwdata_i[0];
      if (tpin_en) tpin_q <= pwdata_i[1:0];
    end
  end

  // identification bytes, one word each
  for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
    assign id_words[g] = (paddr_i == ADDR_W'(OFS_ID0 + 4*g)) ?
                         DATA_W'(ID_WORD[8*g +: 8]) : '0;
  end

  always_comb begin
    id_rd = '0;
    for (int i = 0; i < ID_BYTES; i++) id_rd = id_rd | id_words[i];
  end

  always_comb begin
    case (paddr_i)
      OFS_LOAD:  prdata_o = DATA_W'(load_q);
      OFS_COUNT: prdata_o = DATA_W'(cnt_i);
      OFS_CTRL:  prdata_o = DATA_W'({rst_en_q, run_q});
      OFS_RAW:   prdata_o = DATA_W'(pend_i);
      OFS_MSK:   prdata_o = DATA_W'(pend_i & run_q);
      OFS_KEY:   prdata_o = DATA_W'(lock_q);
      OFS_TSEL:  prdata_o = DATA_W'(tsel_q);
      OFS_TPIN:  prdata_o = DATA_W'(tpin_q);
      default:   prdata_o = id_rd;
    endcase
  end

  assign load_wr_o  = load_en;
  assign load_new_o = wclamp;
  assign load_q_o   = load_q;
  assign ack_wr_o   = open_wr && (paddr_i == OFS_ACK);
  assign run_o      = run_q;
  assign rst_en_o   = rst_en_q;
  assign tsel_o     = tsel_q;
  assign tpin_o     = tpin_q;

  assert_locked_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && acc && paddr_i == OFS_CTRL) |=> $stable({run_q, rst_en_q}));
  assert_key_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && paddr_i == OFS_KEY && pwdata_i == UNLOCK_KEY) |=> !lock_q);
  assert_reload_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_q != '0);
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int               CNT_W      = 32,
  parameter logic [CNT_W-1:0] RESET_LOAD = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             rst_en_i,
  input  logic             load_wr_i,
  input  logic [CNT_W-1:0] load_new_i,
  input  logic [CNT_W-1:0] load_q_i,
  input  logic             ack_wr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pend_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic pend_q, pend_d, flag_q, flag_d;
  logic cnt_en, expire;

  // next-state: reload write > acknowledge > running decrement
  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    flag_d = flag_q;
    expire = 1'b0;
    if (load_wr_i) begin
      cnt_d = load_new_i;
    end else if (ack_wr_i) begin
      cnt_d  = load_q_i;
      pend_d = 1'b0;
    end else if (run_i) begin
      if (cnt_q == CNT_W'(1)) begin
        expire = 1'b1;
        cnt_d  = load_q_i;
        pend_d = 1'b1;
        if (pend_q && rst_en_i) flag_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
    cnt_en = load_wr_i | ack_wr_i | run_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RESET_LOAD;
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      pend_q <= pend_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;
  assign flag_o = flag_q;

  assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr_i |=> cnt_q == $past(load_new_i));
  assert_never_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);
  assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_wr_i && !ack_wr_i) |=> $stable(cnt_q));
  assert_expire_pends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend_q);
  assert_request_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr_i && !load_wr_i) |=> !pend_q);
endmodule

// File: rtl/wdog_pins.sv
module wdog_pins (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tsel_i,
  input  logic [1:0] tpin_i,
  input  logic       pend_i,
  input  logic       run_i,
  input  logic       flag_i,
  input  logic       rst_en_i,
  output logic       irq_o,
  output logic       rst_req_o
);
  always_comb begin
    if (tsel_i) begin
      irq_o     = tpin_i[0];
      rst_req_o = tpin_i[1];
    end else begin
      irq_o     = pend_i & run_i;
      rst_req_o = flag_i & rst_en_i;
    end
  end

  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tsel_i && !run_i) |-> !irq_o);
  assert_reset_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tsel_i && !rst_en_i) |-> !rst_req_o);
  assert_test_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tsel_i |-> (irq_o == tpin_i[0] && rst_req_o == tpin_i[1]));
endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
  import wdog_pkg::*;
#(
  parameter int               CNT_W      = 32,
  parameter logic [CNT_W-1:0] RESET_LOAD = '1,
  parameter int               ID_BYTES   = 4,
  parameter logic [8*ID_BYTES-1:0] ID_WORD = 32'h5744_4F47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic rst_sync_n;
  logic load_wr, ack_wr, run, rst_en, tsel, pend, flag;
  logic [CNT_W-1:0] load_new, load_q, cnt;
  logic [1:0] tpin;

  wdog_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  wdog_regs #(.CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD),
              .ID_BYTES(ID_BYTES), .ID_WORD(ID_WORD)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .cnt_i(cnt), .pend_i(pend),
    .load_wr_o(load_wr), .load_new_o(load_new), .load_q_o(load_q),
    .ack_wr_o(ack_wr), .run_o(run), .rst_en_o(rst_en),
    .tsel_o(tsel), .tpin_o(tpin));

  wdog_count #(.CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD)) u_count (
    .clk(clk), .rst_n(rst_sync_n),
    .run_i(run), .rst_en_i(rst_en),
    .load_wr_i(load_wr), .load_new_i(load_new), .load_q_i(load_q),
    .ack_wr_i(ack_wr),
    .cnt_o(cnt), .pend_o(pend), .flag_o(flag));

  wdog_pins u_pins (
    .clk(clk), .rst_n(rst_sync_n),
    .tsel_i(tsel), .tpin_i(tpin), .pend_i(pend), .run_i(run),
    .flag_i(flag), .rst_en_i(rst_en),
    .irq_o(irq_o), .rst_req_o(rst_req_o));
endmodule

// File: tb/wdog_lockable_tb_top.sv
`timescale 1ns/1ps
module wdog_lockable_tb_top;
  localparam logic [31:0] KEY = 32'h1ACC_E551;
  localparam logic [31:0] RST_LOAD = 32'hFFFF_FFFF;
  localparam logic [31:0] IDW = 32'h5744_4F47;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic irq_o, rst_req_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_lockable dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o));

  // behavioural reference
  logic [31:0] m_load, m_cnt;
  bit m_pend, m_flag, m_run, m_rsten, m_lock, m_tsel;
  logic [1:0] m_tpin;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_load = RST_LOAD; m_cnt = RST_LOAD; m_pend = 0; m_flag = 0;
      m_run = 0; m_rsten = 0; m_lock = 0; m_tsel = 0; m_tpin = 0;
    end else begin
      bit wr;
      logic [31:0] nl;
      wr = psel && penable && pwrite;
      nl = (pwdata == 0) ? 32'd1 : pwdata;
      if (wr && !m_lock && paddr == 8'h00) m_cnt = nl;
      else if (wr && !m_lock && paddr == 8'h0C) begin
        m_cnt = m_load; m_pend = 0;
      end else if (m_run) begin
        if (m_cnt == 1) begin
          if (m_pend && m_rsten) m_flag = 1;
          m_pend = 1; m_cnt = m_load;
        end else m_cnt = m_cnt - 1;
      end
      if (wr) begin
        if (paddr == 8'h18) m_lock = (pwdata != KEY);
        else if (!m_lock) begin
          case (paddr)
            8'h00: m_load = nl;
            8'h08: begin m_run = pwdata[0]; m_rsten = pwdata[1]; end
            8'h1C: m_tsel = pwdata[0];
            8'h20: m_tpin = pwdata[1:0];
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return m_load;
      8'h04: return m_cnt;
      8'h08: return {30'b0, m_rsten, m_run};
      8'h10: return {31'b0, m_pend};
      8'h14: return {31'b0, m_pend & m_run};
      8'h18: return {31'b0, m_lock};
      8'h1C: return {31'b0, m_tsel};
      8'h20: return {30'b0, m_tpin};
      8'h30: return {24'b0, IDW[7:0]};
      8'h34: return {24'b0, IDW[15:8]};
      8'h38: return {24'b0, IDW[23:16]};
      8'h3C: return {24'b0, IDW[31:24]};
      default: return 32'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // pins compared on every falling edge (R5, R6, R7, R10, R12)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ei, er;
      ei = m_tsel ? m_tpin[0] : (m_pend && m_run);
      er = m_tsel ? m_tpin[1] : (m_flag && m_rsten);
      check(irq_o === ei, "R6 irq pin", {31'b0, irq_o}, {31'b0, ei});
      check(rst_req_o === er, "R5 reset pin", {31'b0, rst_req_o}, {31'b0, er});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1 check(prdata === model_read(a), req, prdata, model_read(a));
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(4);
  endtask

  task automatic finish_run;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    do_reset();
    // R12 reset state, R11 identification
    rd(8'h00, "R12 reload");
    rd(8'h04, "R12 count");
    rd(8'h08, "R12 control");
    rd(8'h10, "R12 raw");
    rd(8'h18, "R9 reset unlocked");
    rd(8'h20, "R12 test pins");
    for (int i = 0; i < 4; i++) rd(8'h30 + 8'(4*i), "R11 id byte");
    rd(8'h40, "R11 unmapped");

    // R1 restart, R3 count read-only
    wr(8'h00, 32'd5);
    rd(8'h04, "R1 count restarted");
    rd(8'h00, "R1 reload");
    wr(8'h04, 32'h77);
    rd(8'h04, "R3 count ignores write");

    // R4 running, R7 expiry, R6 raw vs masked
    wr(8'h08, 32'h1);
    idle(2);
    rd(8'h04, "R4 count running");
    idle(8);
    rd(8'h10, "R7 raw after expiry");
    rd(8'h14, "R6 masked");
    wr(8'h08, 32'h0);
    rd(8'h10, "R6 raw when disabled");
    rd(8'h14, "R6 masked when disabled");
    rd(8'h04, "R4 count held");
    rd(8'h04, "R4 count still held");

    // R8 acknowledge
    wr(8'h0C, 32'h0);
    rd(8'h10, "R8 pending cleared");
    rd(8'h04, "R8 count reloaded");

    // R7 reset request via second expiry, R5 gating
    wr(8'h08, 32'h3);
    idle(15);
    wr(8'h08, 32'h1);
    idle(3);
    wr(8'h08, 32'h3);
    idle(3);

    // R2 zero reload
    do_reset();
    wr(8'h00, 32'h0);
    rd(8'h04, "R2 count is one");
    rd(8'h00, "R2 reload is one");

    // R9 lock
    wr(8'h18, 32'h1234);
    rd(8'h18, "R9 locked reads 1");
    wr(8'h08, 32'h3);
    rd(8'h08, "R9 control write ignored");
    wr(8'h00, 32'd9);
    rd(8'h00, "R9 reload write ignored");
    wr(8'h18, KEY);
    rd(8'h18, "R9 unlocked reads 0");
    wr(8'h08, 32'h1);
    rd(8'h08, "R9 control after unlock");

    // R5 reset disabled with repeated expiries
    wr(8'h00, 32'd3);
    idle(20);
    rd(8'h10, "R5 raw pending");

    // R10 test mode
    wr(8'h20, 32'h2);
    wr(8'h1C, 32'h1);
    idle(2);
    rd(8'h1C, "R10 test select");
    wr(8'h20, 32'h1);
    idle(2);
    wr(8'h1C, 32'h0);
    idle(2);
    finish_run();
  end
endmodule